// File: doc/BRIEF.md
# Saturating Wiper Position Counter with One-Hot Tap Select

This block holds the wiper position of one 64-tap resistive selector. The position can be set in three ways, listed from highest to lowest priority: a direct value from the host, a copy of one of four stored settings chosen by an index, or single steps taken while an increment/decrement command is in force. It drives the position and a registered one-hot vector with one enable per tap. Tap 0 joins the wiper to the low terminal, and the all-ones tap joins it to the high terminal.

In step mode the block watches the filtered serial clock and data levels from the bus front end. Each rising edge of the clock counts as one step. The data level at that edge sets the direction: high steps toward the high terminal and low steps toward the low terminal. The command decoder raises the step enable once the increment/decrement command is acknowledged and drops it on the next start or stop. The position is volatile. At reset it takes the value of stored setting 0, which is presented on its own input.

Top module: `wiper_pos_ctl`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `pos` equals `reset_pos` and `tap_en` has only bit `reset_pos` set.
- R2: When `host_ld` is high at a clock edge, `pos` takes `host_val` at that edge, whatever the bank load and step inputs are doing.
- R3: When `bank_ld` is high and `host_ld` is low, `pos` takes entry `bank_sel` of `bank_vals`. Entry k sits in bits [6k+5:6k].
- R4: With `step_en` high and no load, a low-to-high change of `scl_lvl` with `sda_lvl` high raises `pos` by exactly one. Holding `scl_lvl` high adds no further steps.
- R5: With `step_en` high and no load, a low-to-high change of `scl_lvl` with `sda_lvl` low lowers `pos` by exactly one.
- R6: An up step at 3Fh leaves `pos` at 3Fh, and a down step at 00h leaves `pos` at 00h.
- R7: With `step_en` low and no load, activity on `scl_lvl` and `sda_lvl` leaves `pos` unchanged.
- R8: A change of `sda_lvl` while `scl_lvl` stays high, as in a start or stop condition, does not step `pos`, even with `step_en` high.
- R9: `tap_en` always has exactly one bit set, and that bit is bit `pos`. It changes on the same clock edge as `pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_pos | input | 6 | Stored setting 0, loaded at reset |
| host_ld | input | 1 | Direct host write strobe |
| host_val | input | 6 | Value for a direct host write |
| bank_ld | input | 1 | Load strobe from a stored setting |
| bank_sel | input | 2 | Index of the stored setting to load |
| bank_vals | input | 24 | Four stored settings, entry k in bits [6k+5:6k] |
| step_en | input | 1 | Increment/decrement command active |
| scl_lvl | input | 1 | Filtered serial clock level |
| sda_lvl | input | 1 | Filtered serial data level |
| pos | output | 6 | Wiper position |
| tap_en | output | 64 | One-hot tap enables |

## Verification
The bench drives the position into both rails and keeps stepping. A counter that wraps instead of saturating would jump from 3Fh to 00h or from 00h to 3Fh. It holds the clock high across several cycles and toggles data under it. A design that treated a level as a step, or that stepped on a data edge, would move too far or move during a start or stop. It applies all three load sources in the same cycle to expose a wrong priority, and it checks every cycle that the tap vector follows the position with no lag. A one-cycle lag would leave a stale tap enabled after each move.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int POS_W_DEF  = 6;
    localparam int N_BANK_DEF = 4;

    // one decoded step request from the bus levels
    typedef struct packed {
        logic valid;
        logic up;
    } step_req_t;

    // which source feeds the position register this cycle
    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_HOST,
        SRC_BANK,
        SRC_STEP
    } pos_src_e;

endpackage

// File: rtl/wpc_step_det.sv
module wpc_step_det
    import wpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_en,
    input  logic      scl_lvl,
    input  logic      sda_lvl,
    output step_req_t req
);

    // idle bus rests high, so a clock already high at reset is not an edge
    logic scl_q;

    always_ff @(posedge clk) begin
        if (rst) scl_q <= 1'b1;
        else     scl_q <= scl_lvl;
    end

    always_comb begin
        req.valid = step_en & scl_lvl & ~scl_q;
        req.up    = sda_lvl;
    end

endmodule

// File: rtl/wpc_pos_reg.sv
module wpc_pos_reg
    import wpc_pkg::*;
#(
    parameter int POS_W  = POS_W_DEF,
    parameter int N_BANK = N_BANK_DEF,
    localparam int SEL_W = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [POS_W-1:0]        reset_pos,
    input  logic                    host_ld,
    input  logic [POS_W-1:0]        host_val,
    input  logic                    bank_ld,
    input  logic [SEL_W-1:0]        bank_sel,
    input  logic [N_BANK*POS_W-1:0] bank_vals,
    input  step_req_t               req,
    output logic [POS_W-1:0]        pos,
    output logic [POS_W-1:0]        pos_nxt
);

    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] BOT = '0;

    logic [POS_W-1:0] bank_arr [N_BANK];
    pos_src_e         src;

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        assign bank_arr[g] = bank_vals[g*POS_W +: POS_W];
    end

    always_comb begin
        if (host_ld)        src = SRC_HOST;
        else if (bank_ld)   src = SRC_BANK;
        else if (req.valid) src = SRC_STEP;
        else                src = SRC_HOLD;
    end

    always_comb begin
        pos_nxt = pos;
        if (rst) begin
            pos_nxt = reset_pos;
        end else begin
            case (src)
                SRC_HOST: pos_nxt = host_val;
                SRC_BANK: pos_nxt = bank_arr[bank_sel];
                SRC_STEP: begin
                    if (req.up) pos_nxt = (pos == TOP) ? pos : pos + 1'b1;
                    else        pos_nxt = (pos == BOT) ? pos : pos - 1'b1;
                end
                default:  pos_nxt = pos;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        pos <= pos_nxt;
    end

endmodule

// File: rtl/wpc_tap_dec.sv
module wpc_tap_dec #(
    parameter int POS_W = 6,
    localparam int N_TAP = 1 << POS_W
) (
    input  logic             clk,
    input  logic [POS_W-1:0] pos_nxt,
    output logic [N_TAP-1:0] tap_en
);

    logic [N_TAP-1:0] tap_d;

    for (genvar t = 0; t < N_TAP; t++) begin : g_tap
        assign tap_d[t] = (pos_nxt == POS_W'(t));
    end

    // decoded from the next position so taps move on the same edge as pos
    always_ff @(posedge clk) begin
        tap_en <= tap_d;
    end

endmodule

// File: rtl/wiper_pos_ctl.sv
module wiper_pos_ctl
    import wpc_pkg::*;
#(
    parameter int POS_W  = POS_W_DEF,
    parameter int N_BANK = N_BANK_DEF,
    localparam int SEL_W = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int N_TAP = 1 << POS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [POS_W-1:0]        reset_pos,
    input  logic                    host_ld,
    input  logic [POS_W-1:0]        host_val,
    input  logic                    bank_ld,
    input  logic [SEL_W-1:0]        bank_sel,
    input  logic [N_BANK*POS_W-1:0] bank_vals,
    input  logic                    step_en,
    input  logic                    scl_lvl,
    input  logic                    sda_lvl,
    output logic [POS_W-1:0]        pos,
    output logic [N_TAP-1:0]        tap_en
);

    step_req_t        req;
    logic [POS_W-1:0] pos_nxt;

    wpc_step_det u_step (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .req     (req)
    );

    wpc_pos_reg #(.POS_W(POS_W), .N_BANK(N_BANK)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .reset_pos (reset_pos),
        .host_ld   (host_ld),
        .host_val  (host_val),
        .bank_ld   (bank_ld),
        .bank_sel  (bank_sel),
        .bank_vals (bank_vals),
        .req       (req),
        .pos       (pos),
        .pos_nxt   (pos_nxt)
    );

    wpc_tap_dec #(.POS_W(POS_W)) u_dec (
        .clk     (clk),
        .pos_nxt (pos_nxt),
        .tap_en  (tap_en)
    );

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int POS_W = 6,
    localparam int N_TAP = 1 << POS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             host_ld,
    input logic [POS_W-1:0] host_val,
    input logic             bank_ld,
    input logic             step_en,
    input logic             scl_lvl,
    input logic             sda_lvl,
    input logic [POS_W-1:0] pos,
    input logic [N_TAP-1:0] tap_en
);

    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    // R9
    tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(tap_en) == 1) && tap_en[pos]);

    // R2
    host_load_chk: assert property (@(posedge clk) disable iff (rst)
        host_ld |=> (pos == $past(host_val)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !host_ld && !bank_ld) |=> $stable(pos));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_en && scl_lvl && !$past(scl_lvl) && sda_lvl
         && !host_ld && !bank_ld && pos != TOP)
        |=> (pos == POS_W'($past(pos) + 1'b1)));

    // R6
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_en && scl_lvl && !$past(scl_lvl) && sda_lvl
         && !host_ld && !bank_ld && pos == TOP) |=> (pos == TOP));

    // R6
    sat_bot_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_en && scl_lvl && !$past(scl_lvl) && !sda_lvl
         && !host_ld && !bank_ld && pos == '0) |=> (pos == '0));

    // R8
    sda_under_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && scl_lvl && $past(scl_lvl) && !host_ld && !bank_ld)
        |=> $stable(pos));

endmodule

bind wiper_pos_ctl wpc_checker #(.POS_W(POS_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .host_ld  (host_ld),
    .host_val (host_val),
    .bank_ld  (bank_ld),
    .step_en  (step_en),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .pos      (pos),
    .tap_en   (tap_en)
);

// File: tb/wiper_pos_ctl_tb_top.sv
module wiper_pos_ctl_tb_top;

    typedef struct {
        logic [5:0] pos;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reset_pos = 6'h15;
    logic        host_ld = 1'b0;
    logic [5:0]  host_val = '0;
    logic        bank_ld = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [23:0] bank_vals = {6'h00, 6'h20, 6'h3E, 6'h03};
    logic        step_en = 1'b0;
    logic        scl_lvl = 1'b1;
    logic        sda_lvl = 1'b1;
    logic [5:0]  pos;
    logic [63:0] tap_en;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    logic [5:0] m_pos;
    logic       m_scl;

    always #2.5 clk = ~clk;

    wiper_pos_ctl dut_i (
        .clk(clk), .rst(rst), .reset_pos(reset_pos),
        .host_ld(host_ld), .host_val(host_val),
        .bank_ld(bank_ld), .bank_sel(bank_sel), .bank_vals(bank_vals),
        .step_en(step_en), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .pos(pos), .tap_en(tap_en)
    );

    function automatic logic [5:0] bank_entry(input logic [1:0] s);
        return bank_vals[s*6 +: 6];
    endfunction

    // driver: apply one cycle of stimulus, model the edge, push expectation
    task automatic drive(input logic hl, input logic [5:0] hv, input logic bl,
                         input logic [1:0] bs, input logic en, input logic scl,
                         input logic sda, input string tag);
        @(negedge clk);
        host_ld = hl; host_val = hv; bank_ld = bl; bank_sel = bs;
        step_en = en; scl_lvl = scl; sda_lvl = sda;
        @(posedge clk);
        if (rst) begin
            m_pos = reset_pos;
            m_scl = 1'b1;
        end else begin
            if (hl)                       m_pos = hv;
            else if (bl)                  m_pos = bank_entry(bs);
            else if (en && scl && !m_scl) begin
                if (sda) m_pos = (m_pos == 6'h3F) ? m_pos : m_pos + 6'd1;
                else     m_pos = (m_pos == 6'h00) ? m_pos : m_pos - 6'd1;
            end
            m_scl = scl;
        end
        #1;
        q.push_back('{pos: m_pos, tag: tag});
    endtask

    task automatic step_pulse(input logic dir, input string tag);
        drive(1'b0, 6'h0, 1'b0, 2'd0, 1'b1, 1'b0, dir, tag);
        drive(1'b0, 6'h0, 1'b0, 2'd0, 1'b1, 1'b1, dir, tag);
    endtask

    // monitor: compare popped expectations with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pos !== e.pos) begin
                    errors++;
                    $display("FAIL %s pos actual=%02h expected=%02h", e.tag, pos, e.pos);
                end
                checks++;
                if (tap_en !== (64'd1 << e.pos)) begin
                    errors++;
                    $display("FAIL R9 tap_en actual=%016h expected=%016h",
                             tap_en, 64'd1 << e.pos);
                end
            end
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pos = 6'h15;
        m_scl = 1'b1;
        // R1: reset state, scl held high
        for (int i = 0; i < 3; i++) drive(0, 6'h0, 0, 2'd0, 0, 1, 1, "R1");
        @(negedge clk); rst = 1'b0;
        drive(0, 6'h0, 0, 2'd0, 0, 1, 1, "R1");
        // R7: bus activity with step mode off
        for (int i = 0; i < 4; i++) begin
            drive(0, 6'h0, 0, 2'd0, 0, 0, i[0], "R7");
            drive(0, 6'h0, 0, 2'd0, 0, 1, i[0], "R7");
        end
        // R4: up steps, then clock held high
        step_pulse(1'b1, "R4");
        for (int i = 0; i < 3; i++) drive(0, 6'h0, 0, 2'd0, 1, 1, 1, "R4");
        step_pulse(1'b1, "R4");
        // R5: down steps
        for (int i = 0; i < 3; i++) step_pulse(1'b0, "R5");
        // R8: data toggles under a high clock
        drive(0, 6'h0, 0, 2'd0, 1, 1, 0, "R8");
        drive(0, 6'h0, 0, 2'd0, 1, 1, 1, "R8");
        drive(0, 6'h0, 0, 2'd0, 1, 1, 0, "R8");
        drive(0, 6'h0, 0, 2'd0, 1, 1, 1, "R8");
        // R3: each stored setting
        for (int s = 0; s < 4; s++) drive(0, 6'h0, 1, 2'(s), 0, 1, 1, "R3");
        // R3: bank load wins over a step edge
        drive(0, 6'h0, 0, 2'd0, 1, 0, 1, "R3");
        drive(0, 6'h0, 1, 2'd2, 1, 1, 1, "R3");
        // R2: host load wins over bank load and a step edge
        drive(0, 6'h0, 0, 2'd0, 1, 0, 0, "R2");
        drive(1, 6'h2A, 1, 2'd1, 1, 1, 0, "R2");
        // R6: top rail
        drive(1, 6'h3E, 0, 2'd0, 1, 1, 1, "R6");
        for (int i = 0; i < 3; i++) step_pulse(1'b1, "R6");
        // R6: bottom rail
        drive(1, 6'h01, 0, 2'd0, 1, 1, 0, "R6");
        for (int i = 0; i < 3; i++) step_pulse(1'b0, "R6");
        // R9: random mix of all inputs
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0] & r[1] & r[2], r[13:8], r[3] & r[4] & r[5], r[7:6],
                  r[14] | r[15], r[16], r[17], "R9");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule